// File: doc/BRIEF.md
# ATA Strobe Timing Generator

This block produces the active-low read and write strobes for a parallel ATA channel. It covers programmed-I/O and multiword DMA data cycles as well as task-file register cycles. One cycle is launched with a single-clock start request. With that request come a cycle kind (data or command), a direction and a packed 32-bit timing word. The word sets how long the strobe stays low, how long it then recovers high, and an optional setup interval placed ahead of the first strobe of a burst. Data cycles and command cycles have their own sets of fields.

The timing word is captured when a cycle is accepted, so software may reload the timing register at any moment without disturbing a cycle in flight. A burst input lets a controller chain requests. While burst stays high, only the first cycle pays the setup interval. Dropping burst for at least one clock arms the setup again. Four mode flags in the top nibble of the word are captured with the timings and presented to neighbouring logic, which decodes them by position.

Top module: `ata_strobe_gen`

## Requirements
- R1: In a data cycle (kind input low) the selected strobe is low for exactly word[8:4]+1 clocks.
- R2: In a data cycle, after the low phase, the strobe stays high for exactly word[3:0]+1 clocks before done pulses.
- R3: In a command cycle (kind input high) the low time is word[17:13]+1 clocks and the recovery time is word[12:9]+1 clocks; the data fields have no effect.
- R4: A cycle that opens a burst waits word[24:22]+1 clocks (data) or word[27:25]+1 clocks (command) with both strobes high before the strobe falls. The wait is counted from the clock after the start is accepted.
- R5: A read (direction input high) pulses only the read strobe and a write pulses only the write strobe; the two strobes are never low together.
- R6: busy rises on the clock after an accepted start and stays high to the end of the recovery phase. done is high for exactly one clock, on the clock after the last recovery clock, and busy is low in that clock. A new start may be accepted in the done clock.
- R7: While burst stays high, a cycle after the first one skips the setup wait, and its strobe falls on the clock after acceptance. Holding burst low for at least one clock while idle re-arms the setup wait.
- R8: The timing word, kind and direction are sampled when a start is accepted. Later changes to them do not alter the cycle in progress.
- R9: A start request made while busy is high is ignored: the cycle in progress keeps its length and no extra cycle follows.
- R10: flags[3:0] present word bits [31:28] (bit 0 = word bit 28 UDMA enable, bit 1 = bit 29 DMA enable, bit 2 = bit 30 PIO bus-master, bit 3 = bit 31 FIFO enable). They are captured at acceptance and held until the next accepted start; they do not affect strobe timing.
- R11: While reset is high, and in the first clock after it, both strobes are high and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one strobe cycle (accepted when idle) |
| cyc_cmd | input | 1 | 1 = task-file command cycle, 0 = data cycle |
| rd_sel | input | 1 | 1 = read strobe, 0 = write strobe |
| burst | input | 1 | High while requests are chained; low re-arms the setup wait |
| tword | input | 32 | Packed timing word |
| dior_n | output | 1 | Active-low read strobe (registered) |
| diow_n | output | 1 | Active-low write strobe (registered) |
| busy | output | 1 | Cycle in progress (registered) |
| done | output | 1 | One-clock end-of-cycle pulse (registered) |
| flags | output | 4 | Mode flags captured from tword[31:28] |

## Verification
A phase counter that loads the wrong field, or that reloads from the live word instead of the captured copy, shows up as a strobe pulse that is one or more clocks too long or too short. This is visible at the ports within the cycle that follows the error. A stale setup-arming flag moves the falling edge of the strobe on the next request, by exactly the setup length. A state register stuck outside idle shows as busy never falling and done never pulsing, so the run ends at the bounded wait on done. A direction latch that is wrong drives the opposite strobe on the very first low clock.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 5;
  localparam int FLAG_W = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_LOW  = 2'd2,
    PH_HIGH = 2'd3
  } phase_t;

  typedef struct packed {
    logic [CNT_W-1:0] pre;
    logic [CNT_W-1:0] low;
    logic [CNT_W-1:0] high;
  } widths_t;
endpackage

// File: rtl/ata_tw_select.sv
module ata_tw_select
  import ata_strobe_pkg::*;
(
  input  logic [WORD_W-1:0] tw,
  input  logic              cmd,
  output widths_t           live,
  output logic [FLAG_W-1:0] live_flags
);
  logic [3:0] unused_udma_clk;
  assign unused_udma_clk = tw[21:18];

  always_comb begin
    if (cmd) begin
      live.pre  = CNT_W'(tw[27:25]);
      live.low  = CNT_W'(tw[17:13]);
      live.high = CNT_W'(tw[12:9]);
    end else begin
      live.pre  = CNT_W'(tw[24:22]);
      live.low  = CNT_W'(tw[8:4]);
      live.high = CNT_W'(tw[3:0]);
    end
  end

  assign live_flags = tw[WORD_W-1 -: FLAG_W];
endmodule

// File: rtl/ata_tw_hold.sv
module ata_tw_hold
  import ata_strobe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  widths_t           live,
  input  logic [FLAG_W-1:0] live_flags,
  input  logic              rd_in,
  output widths_t           held,
  output logic [FLAG_W-1:0] held_flags,
  output logic              held_rd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held       <= '0;
      held_flags <= '0;
      held_rd    <= 1'b0;
    end else if (accept) begin
      held       <= live;
      held_flags <= live_flags;
      held_rd    <= rd_in;
    end
  end
endmodule

// File: rtl/ata_phase_ctrl.sv
module ata_phase_ctrl
  import ata_strobe_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    burst,
  input  widths_t live,
  input  widths_t held,
  output logic    accept,
  output phase_t  ph_nx,
  output logic    done_nx
);
  phase_t           ph_q;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             first_q;

  assign accept = start && (ph_q == PH_IDLE);

  always_comb begin
    ph_nx   = ph_q;
    cnt_nx  = cnt_q;
    done_nx = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (accept) begin
        if (first_q) begin ph_nx = PH_PRE; cnt_nx = live.pre; end
        else         begin ph_nx = PH_LOW; cnt_nx = live.low; end
      end
      PH_PRE: begin
        if (cnt_q == '0) begin ph_nx = PH_LOW; cnt_nx = held.low; end
        else cnt_nx = cnt_q - 1'b1;
      end
      PH_LOW: begin
        if (cnt_q == '0) begin ph_nx = PH_HIGH; cnt_nx = held.high; end
        else cnt_nx = cnt_q - 1'b1;
      end
      PH_HIGH: begin
        if (cnt_q == '0) begin ph_nx = PH_IDLE; done_nx = 1'b1; end
        else cnt_nx = cnt_q - 1'b1;
      end
      default: ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else begin
      ph_q  <= ph_nx;
      cnt_q <= cnt_nx;
      if (accept)      first_q <= 1'b0;
      else if (!burst) first_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ata_strobe_out.sv
module ata_strobe_out
  import ata_strobe_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t ph_nx,
  input  logic   rd_nx,
  input  logic   done_nx,
  output logic   dior_n,
  output logic   diow_n,
  output logic   busy,
  output logic   done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dior_n <= 1'b1;
      diow_n <= 1'b1;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      dior_n <= !((ph_nx == PH_LOW) && rd_nx);
      diow_n <= !((ph_nx == PH_LOW) && !rd_nx);
      busy   <= (ph_nx != PH_IDLE);
      done   <= done_nx;
    end
  end
endmodule

// File: rtl/ata_strobe_gen.sv
module ata_strobe_gen
  import ata_strobe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cyc_cmd,
  input  logic              rd_sel,
  input  logic              burst,
  input  logic [WORD_W-1:0] tword,
  output logic              dior_n,
  output logic              diow_n,
  output logic              busy,
  output logic              done,
  output logic [FLAG_W-1:0] flags
);
  widths_t           live, held;
  logic [FLAG_W-1:0] live_flags;
  logic              accept, held_rd, rd_nx, done_nx;
  phase_t            ph_nx;

  ata_tw_select u_sel (
    .tw(tword), .cmd(cyc_cmd), .live(live), .live_flags(live_flags)
  );

  ata_tw_hold u_hold (
    .clk(clk), .rst(rst), .accept(accept), .live(live), .live_flags(live_flags),
    .rd_in(rd_sel), .held(held), .held_flags(flags), .held_rd(held_rd)
  );

  ata_phase_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .burst(burst), .live(live), .held(held),
    .accept(accept), .ph_nx(ph_nx), .done_nx(done_nx)
  );

  assign rd_nx = accept ? rd_sel : held_rd;

  ata_strobe_out u_out (
    .clk(clk), .rst(rst), .ph_nx(ph_nx), .rd_nx(rd_nx), .done_nx(done_nx),
    .dior_n(dior_n), .diow_n(diow_n), .busy(busy), .done(done)
  );
endmodule

// File: rtl/ata_strobe_chk.sv
module ata_strobe_chk
  import ata_strobe_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              dior_n,
  input logic              diow_n,
  input logic              busy,
  input logic              done,
  input logic [FLAG_W-1:0] flags
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always @(negedge clk) begin
    if (rst_d === 1'b1)
      assert_reset_idle_R11: assert (dior_n && diow_n && !busy && !done);
  end

  assert_no_double_low_R5: assert property (@(posedge clk) disable iff (rst)
    !(!dior_n && !diow_n));

  assert_low_within_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (!dior_n || !diow_n) |-> busy);

  assert_accept_sets_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  assert_done_ends_busy_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(flags));
endmodule

bind ata_strobe_gen ata_strobe_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .dior_n(dior_n), .diow_n(diow_n),
  .busy(busy), .done(done), .flags(flags)
);

// File: tb/ata_strobe_gen_tb_top.sv
module ata_strobe_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, cyc_cmd = 1'b0, rd_sel = 1'b0, burst = 1'b0;
  logic [31:0] tword = '0;
  logic        dior_n, diow_n, busy, done;
  logic [3:0]  flags;
  int          total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;

  ata_strobe_gen dut_i (
    .clk(clk), .rst(rst), .start(start), .cyc_cmd(cyc_cmd), .rd_sel(rd_sel),
    .burst(burst), .tword(tword), .dior_n(dior_n), .diow_n(diow_n),
    .busy(busy), .done(done), .flags(flags)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int dpre, dlow, dhigh, cpre, clow, chigh, input logic [3:0] fl);
    logic [31:0] w = '0;
    w[3:0] = 4'(dhigh);  w[8:4] = 5'(dlow);
    w[12:9] = 4'(chigh); w[17:13] = 5'(clow);
    w[24:22] = 3'(dpre); w[27:25] = 3'(cpre);
    w[31:28] = fl;
    return w;
  endfunction

  task automatic issue(input logic cmd, input logic rd, input logic [31:0] w);
    cyc_cmd = cmd; rd_sel = rd; tword = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // samples from the first negedge after acceptance up to the done sample
  task automatic measure(input logic rd, input bit poke, input string req,
                         output int npre, output int nlow, output int nhigh);
    int n = 0;
    npre = 0; nlow = 0; nhigh = 0;
    while (!done && n < 300) begin
      if (poke && n == 1) start = 1'b1;
      if (poke && n == 2) start = 1'b0;
      if (!busy) check(0, {req, " busy"}, 0, 1);
      if ((rd ? !diow_n : !dior_n)) check(0, "R5 wrong strobe", 1, 0);
      if ((rd ? !dior_n : !diow_n)) nlow++;
      else if (nlow == 0) npre++;
      else nhigh++;
      n++;
      @(negedge clk);
    end
    check(done === 1'b1, {req, " done seen"}, done, 1);
    check(busy === 1'b0, "R6 busy low at done", busy, 0);
  endtask

  task automatic expect_lens(input string req, input int gp, gl, gh, ep, el, eh);
    check(gp == ep, {req, " setup"}, gp, ep);
    check(gl == el, {req, " low"}, gl, el);
    check(gh == eh, {req, " high"}, gh, eh);
  endtask

  task automatic t_reset();
    check(dior_n && diow_n, "R11 strobes high", {dior_n, diow_n}, 3);
    check(!busy && !done, "R11 busy/done low", {busy, done}, 0);
  endtask

  task automatic t_data_read();
    int p, l, h;
    issue(0, 1, mk(2, 3, 1, 6, 9, 9, 4'h0));
    measure(1, 0, "R1", p, l, h);
    expect_lens("R1/R2/R4 data read", p, l, h, 3, 4, 2);
    @(negedge clk);
    check(done === 1'b0, "R6 done one clock", done, 0);
  endtask

  task automatic t_data_write_zero();
    int p, l, h;
    issue(0, 0, mk(0, 0, 0, 5, 7, 3, 4'h0));
    measure(0, 0, "R5", p, l, h);
    expect_lens("R5/R2 write zero fields", p, l, h, 1, 1, 1);
    @(negedge clk);
  endtask

  task automatic t_cmd();
    int p, l, h;
    issue(1, 1, mk(7, 20, 15, 1, 5, 2, 4'h0));
    measure(1, 0, "R3", p, l, h);
    expect_lens("R3/R4 command read", p, l, h, 2, 6, 3);
    @(negedge clk);
    issue(1, 0, mk(0, 1, 1, 4, 31, 15, 4'h0));
    measure(0, 0, "R3", p, l, h);
    expect_lens("R3 command write", p, l, h, 5, 32, 16);
    @(negedge clk);
  endtask

  task automatic t_burst();
    int p, l, h;
    logic [31:0] w = mk(3, 2, 2, 0, 0, 0, 4'h0);
    burst = 1'b1;
    issue(0, 1, w);
    measure(1, 0, "R7", p, l, h);
    expect_lens("R7 burst first", p, l, h, 4, 3, 3);
    issue(0, 0, w);
    measure(0, 0, "R7", p, l, h);
    expect_lens("R7 burst follow-on", p, l, h, 0, 3, 3);
    burst = 1'b0;
    @(negedge clk);
    burst = 1'b1;
    issue(0, 1, w);
    measure(1, 0, "R7", p, l, h);
    expect_lens("R7 re-armed", p, l, h, 4, 3, 3);
    burst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_sample_word();
    int p, l, h;
    issue(0, 1, mk(1, 4, 3, 0, 0, 0, 4'b1010));
    tword = mk(6, 30, 14, 0, 0, 0, 4'b0101);
    cyc_cmd = 1'b1; rd_sel = 1'b0;
    measure(1, 0, "R8", p, l, h);
    expect_lens("R8 word captured", p, l, h, 2, 5, 4);
    check(flags == 4'b1010, "R10 flags captured", flags, 4'b1010);
    @(negedge clk);
    cyc_cmd = 1'b0;
  endtask

  task automatic t_busy_start();
    int p, l, h;
    issue(0, 0, mk(1, 2, 1, 0, 0, 0, 4'b0011));
    measure(0, 1, "R9", p, l, h);
    expect_lens("R9 start while busy", p, l, h, 2, 3, 2);
    check(flags == 4'b0011, "R10 flags", flags, 4'b0011);
    @(negedge clk);
    check(!busy && diow_n && dior_n, "R9 no extra cycle", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_data_read();
    t_data_write_zero();
    t_cmd();
    t_burst();
    t_sample_word();
    t_busy_start();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule